// File: doc/BRIEF.md
# Copy-Back Line Miss Sequencer

This block is the control state machine of a direct-mapped secondary cache that uses copy-back writes. It handles a read miss on a line of four doublewords. If the line being replaced holds modified data, the sequencer first copies that line out of the cache data RAM into a write buffer. It then fetches the replacement line from memory, one doubleword at a time, and writes each doubleword into the cache.

If the victim line is clean or invalid, the copy-out phase is skipped. The data RAM, tag RAM, dirty-bit store and write buffer are outside the block. The block only drives their strobes and the doubleword index that addresses them.

The copy-out phase stalls while the write buffer reports full. The refill phase stalls until memory signals ready. The primary cache line is invalidated during the copy-out of doubleword 1. The tag is written and the dirty bit cleared together with the refill write of doubleword 2. Once the last refill doubleword is written, the sequencer returns to idle and raises a one-cycle ready pulse for the CPU.

Top module: `cb_miss_seq`

## Requirements
- R1: While rst_ni is low, and in idle with miss_i low, every strobe is low and dw_idx_o is 0.
- R2: A miss seen in idle with both line_valid_i and line_dirty_i high starts the copy-out phase in the next cycle, at doubleword 0, with cache_rd_o high.
- R3: A miss seen in idle with line_valid_i low or line_dirty_i low goes straight to refill doubleword 0 in the next cycle. No cache_rd_o is issued, and wbuf_full_i has no effect on the refill.
- R4: The copy-out phase reads doublewords 0, 1, 2, 3 in that order, with cache_rd_o high and dw_idx_o holding the current doubleword. wbuf_load_o is high in exactly the cycles in which wbuf_full_i is low, and the sequencer then moves to the next doubleword. After doubleword 3 it moves to refill doubleword 0.
- R5: While wbuf_full_i is high during copy-out, dw_idx_o holds, cache_rd_o stays high and wbuf_load_o is low.
- R6: l1_inval_o is high in the copy-out state for doubleword 1, stall cycles included, and at no other time.
- R7: Each refill state holds its doubleword while mem_rdy_i is low, with cache_wr_o low. With mem_rdy_i high, cache_wr_o is high and the sequencer advances through doublewords 0, 1, 2, 3 in order.
- R8: tag_wr_o and dirty_clr_o are high only in the cycle in which refill doubleword 2 is written into the cache.
- R9: After the refill write of doubleword 3 the sequencer returns to idle, and cpu_rdy_o is high for exactly the one following cycle.
- R10: miss_i has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_i | input | 1 | Read miss detected (sampled in idle only) |
| line_valid_i | input | 1 | Victim line valid |
| line_dirty_i | input | 1 | Victim line modified |
| wbuf_full_i | input | 1 | Write buffer cannot accept a doubleword |
| mem_rdy_i | input | 1 | Memory returns the current refill doubleword |
| cache_rd_o | output | 1 | Read strobe to the cache data RAM |
| cache_wr_o | output | 1 | Write strobe to the cache data RAM |
| dw_idx_o | output | 2 | Doubleword index within the line |
| wbuf_load_o | output | 1 | Load the read doubleword into the write buffer |
| l1_inval_o | output | 1 | Invalidate the primary cache line |
| tag_wr_o | output | 1 | Write the new tag |
| dirty_clr_o | output | 1 | Clear the line's dirty bit |
| cpu_rdy_o | output | 1 | Miss complete, one-cycle pulse |

## Verification
The assertions assume that wbuf_full_i, mem_rdy_i and the miss qualifiers are synchronous to clk_i and stable around each rising edge. They also assume that line_valid_i and line_dirty_i describe the victim line in the cycle in which miss_i is seen in idle. The stimulus changes every input only on the falling edge and samples the outputs one nanosecond later, so all inputs are settled at the next rising edge. The stimulus also drives miss_i and wbuf_full_i in phases where they must be ignored, and asserts reset in the middle of a refill.

// File: rtl/cb_seq_pkg.sv
package cb_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EVICT  = 2'd1,
    PH_REFILL = 2'd2
  } phase_e;
endpackage

// File: rtl/cb_seq_next.sv
module cb_seq_next
  import cb_seq_pkg::*;
#(
  parameter int LINE_DW = 4,
  localparam int IDX_W = $clog2(LINE_DW)
) (
  input  phase_e           phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             miss_i,
  input  logic             valid_i,
  input  logic             dirty_i,
  input  logic             full_i,
  input  logic             rdy_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_DW - 1);

  logic last;
  assign last = (idx_i == LAST_IDX);

  always_comb begin
    phase_o = phase_i;
    idx_o   = idx_i;
    done_o  = 1'b0;
    unique case (phase_i)
      PH_IDLE: begin
        idx_o = '0;
        if (miss_i) phase_o = (valid_i && dirty_i) ? PH_EVICT : PH_REFILL;
      end
      PH_EVICT: begin
        if (!full_i) begin
          if (last) begin
            phase_o = PH_REFILL;
            idx_o   = '0;
          end else begin
            idx_o = idx_i + IDX_W'(1);
          end
        end
      end
      PH_REFILL: begin
        if (rdy_i) begin
          if (last) begin
            phase_o = PH_IDLE;
            idx_o   = '0;
            done_o  = 1'b1;
          end else begin
            idx_o = idx_i + IDX_W'(1);
          end
        end
      end
      default: begin
        phase_o = PH_IDLE;
        idx_o   = '0;
      end
    endcase
  end
endmodule

// File: rtl/cb_seq_dec.sv
module cb_seq_dec
  import cb_seq_pkg::*;
#(
  parameter int LINE_DW   = 4,
  parameter int INVAL_IDX = 1,
  parameter int TAG_IDX   = 2,
  localparam int IDX_W = $clog2(LINE_DW)
) (
  input  phase_e           phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             full_i,
  input  logic             rdy_i,
  output logic             rd_o,
  output logic             wr_o,
  output logic             load_o,
  output logic             inval_o,
  output logic             tag_o,
  output logic             dclr_o
);
  logic in_evict, in_refill, tag_dw;

  assign in_evict  = (phase_i == PH_EVICT);
  assign in_refill = (phase_i == PH_REFILL);
  assign tag_dw    = (idx_i == IDX_W'(TAG_IDX));

  assign rd_o    = in_evict;
  assign load_o  = in_evict && !full_i;
  assign inval_o = in_evict && (idx_i == IDX_W'(INVAL_IDX));
  assign wr_o    = in_refill && rdy_i;
  assign tag_o   = in_refill && rdy_i && tag_dw;
  assign dclr_o  = in_refill && rdy_i && tag_dw;
endmodule

// File: rtl/cb_miss_seq.sv
module cb_miss_seq
  import cb_seq_pkg::*;
#(
  parameter int LINE_DW   = 4,
  parameter int INVAL_IDX = 1,
  parameter int TAG_IDX   = 2,
  localparam int IDX_W = $clog2(LINE_DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic             line_valid_i,
  input  logic             line_dirty_i,
  input  logic             wbuf_full_i,
  input  logic             mem_rdy_i,
  output logic             cache_rd_o,
  output logic             cache_wr_o,
  output logic [IDX_W-1:0] dw_idx_o,
  output logic             wbuf_load_o,
  output logic             l1_inval_o,
  output logic             tag_wr_o,
  output logic             dirty_clr_o,
  output logic             cpu_rdy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_DW - 1);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rdy_q, done;

  cb_seq_next #(.LINE_DW(LINE_DW)) u_next (
    .phase_i (phase_q),
    .idx_i   (idx_q),
    .miss_i  (miss_i),
    .valid_i (line_valid_i),
    .dirty_i (line_dirty_i),
    .full_i  (wbuf_full_i),
    .rdy_i   (mem_rdy_i),
    .phase_o (phase_d),
    .idx_o   (idx_d),
    .done_o  (done)
  );

  cb_seq_dec #(.LINE_DW(LINE_DW), .INVAL_IDX(INVAL_IDX), .TAG_IDX(TAG_IDX)) u_dec (
    .phase_i (phase_q),
    .idx_i   (idx_q),
    .full_i  (wbuf_full_i),
    .rdy_i   (mem_rdy_i),
    .rd_o    (cache_rd_o),
    .wr_o    (cache_wr_o),
    .load_o  (wbuf_load_o),
    .inval_o (l1_inval_o),
    .tag_o   (tag_wr_o),
    .dclr_o  (dirty_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      rdy_q   <= done;
    end
  end

  assign dw_idx_o  = idx_q;
  assign cpu_rdy_o = rdy_q;

  // R2
  a_r2_dirty_evicts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && miss_i && line_valid_i && line_dirty_i)
      |=> (cache_rd_o && dw_idx_o == '0));
  // R3
  a_r3_clean_refills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && miss_i && !(line_valid_i && line_dirty_i))
      |=> (!cache_rd_o && phase_q == PH_REFILL && dw_idx_o == '0));
  // R4
  a_r4_evict_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_rd_o && !wbuf_full_i && dw_idx_o != LAST_IDX)
      |=> (cache_rd_o && dw_idx_o == $past(dw_idx_o) + IDX_W'(1)));
  // R5
  a_r5_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_rd_o && wbuf_full_i) |=> (cache_rd_o && $stable(dw_idx_o)));
  // R6
  a_r6_inval_dw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_inval_o |-> (cache_rd_o && dw_idx_o == IDX_W'(INVAL_IDX)));
  // R7
  a_r7_refill_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REFILL && !mem_rdy_i) |=> (phase_q == PH_REFILL && $stable(dw_idx_o)));
  // R8
  a_r8_tag_dw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_wr_o || dirty_clr_o) |-> (cache_wr_o && dw_idx_o == IDX_W'(TAG_IDX)));
  // R9
  a_r9_done_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_wr_o && dw_idx_o == LAST_IDX) |=> (cpu_rdy_o && phase_q == PH_IDLE));
  a_r9_rdy_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rdy_o |=> !cpu_rdy_o);
endmodule

// File: tb/cb_miss_seq_tb.sv
`timescale 1ns/1ps
module cb_miss_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss = 1'b0, valid = 1'b0, dirty = 1'b0, full = 1'b0, rdy = 1'b0;
  logic rd, wr, load, inval, tag, dclr, crdy;
  logic [1:0] idx;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cb_miss_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .miss_i(miss), .line_valid_i(valid),
    .line_dirty_i(dirty), .wbuf_full_i(full), .mem_rdy_i(rdy),
    .cache_rd_o(rd), .cache_wr_o(wr), .dw_idx_o(idx), .wbuf_load_o(load),
    .l1_inval_o(inval), .tag_wr_o(tag), .dirty_clr_o(dclr), .cpu_rdy_o(crdy)
  );

  // {req[3:0], miss valid dirty full rdy, rd wr idx[1:0] load inval tag dclr crdy}
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1,  5'b00000, 9'b0_0_00_0_0_0_0_0},
    {4'd2,  5'b11100, 9'b0_0_00_0_0_0_0_0},
    {4'd5,  5'b00010, 9'b1_0_00_0_0_0_0_0},
    {4'd4,  5'b00000, 9'b1_0_00_1_0_0_0_0},
    {4'd6,  5'b00010, 9'b1_0_01_0_1_0_0_0},
    {4'd6,  5'b00000, 9'b1_0_01_1_1_0_0_0},
    {4'd10, 5'b10000, 9'b1_0_10_1_0_0_0_0},
    {4'd4,  5'b00000, 9'b1_0_11_1_0_0_0_0},
    {4'd7,  5'b00000, 9'b0_0_00_0_0_0_0_0},
    {4'd7,  5'b00001, 9'b0_1_00_0_0_0_0_0},
    {4'd7,  5'b00001, 9'b0_1_01_0_0_0_0_0},
    {4'd7,  5'b00000, 9'b0_0_10_0_0_0_0_0},
    {4'd8,  5'b00001, 9'b0_1_10_0_0_1_1_0},
    {4'd9,  5'b00001, 9'b0_1_11_0_0_0_0_0},
    {4'd9,  5'b00000, 9'b0_0_00_0_0_0_0_1},
    {4'd3,  5'b11000, 9'b0_0_00_0_0_0_0_0},
    {4'd3,  5'b00001, 9'b0_1_00_0_0_0_0_0},
    {4'd3,  5'b00011, 9'b0_1_01_0_0_0_0_0},
    {4'd8,  5'b00001, 9'b0_1_10_0_0_1_1_0},
    {4'd9,  5'b00001, 9'b0_1_11_0_0_0_0_0},
    {4'd3,  5'b10100, 9'b0_0_00_0_0_0_0_1},
    {4'd3,  5'b00001, 9'b0_1_00_0_0_0_0_0}
  };

  function automatic logic [8:0] outs();
    return {rd, wr, idx, load, inval, tag, dclr, crdy};
  endfunction

  task automatic check(input int req, input logic [8:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL R%0d: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  initial begin
    #200_000_000;
    n_bad++;
    $display("FAIL R0: watchdog expired, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: outputs while reset is held
    rdy = 1'b1; full = 1'b1;
    #5 check(1, 9'b0);
    @(negedge clk); check(1, 9'b0);
    rst_n = 1'b1; rdy = 1'b0; full = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      {miss, valid, dirty, full, rdy} = VEC[i][13:9];
      #1 check(int'(VEC[i][17:14]), VEC[i][8:0]);
      @(negedge clk);
    end
    // now in refill dw1: R10 miss ignored while refilling
    {miss, valid, dirty, full, rdy} = 5'b11100;
    #1 check(10, 9'b0_0_01_0_0_0_0_0);
    @(negedge clk);
    {miss, valid, dirty, full, rdy} = 5'b00000;
    #1 check(10, 9'b0_0_01_0_0_0_0_0);
    // R1: asynchronous reset mid-refill
    rdy = 1'b1;
    rst_n = 1'b0;
    #1 check(1, 9'b0);
    @(negedge clk); rst_n = 1'b1; rdy = 1'b0;
    #1 check(1, 9'b0);
    @(negedge clk);
    #1 check(1, 9'b0);
    // R2: dirty miss after reset reaches dw0 of copy-out
    {miss, valid, dirty} = 3'b111;
    @(negedge clk); miss = 1'b0; full = 1'b1;
    #1 check(2, 9'b1_0_00_0_0_0_0_0);
    @(negedge clk);
    #1 check(5, 9'b1_0_00_0_0_0_0_0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule